// File: doc/BRIEF.md
# Speculative Load Tracking Buffer

This block keeps a record of loads that were performed ahead of the point where the memory ordering rules would allow them, and whose data the core has already consumed. Each record holds the load's line address, its reorder-buffer tag and a flag telling whether every access that must precede it has now completed. Records are allocated strictly in program order into a circular store of `DEPTH` slots, with a head pointer at the oldest live record and a tail pointer at the next free slot. A load is offered to the buffer as soon as its address is known; when no slot is free the offer is refused and the core stalls it.

The buffer watches the coherence traffic arriving at the cache: every invalidation or update carries a line address, and it is compared against all live records at once. A hit means the value handed to the core may now be stale. The buffer then drops the oldest hit record and every younger record, and raises a one-cycle squash request with that record's tag, so that the core discards and re-executes the load and everything after it. The cache is never read a second time to confirm a value. A record is released (retired) once the core reports that its ordering condition holds. With `strict_order` high only the oldest record may leave. With it low, the oldest record that has permission leaves, even when an older record is still waiting. At most one record retires per cycle.

Occupancy is tracked by a three-state machine. ST_EMPTY moves to ST_OPEN when a load is accepted. ST_OPEN moves to ST_FULL when the slot at the tail is still live after the update, and back to ST_EMPTY when no live record remains. ST_FULL moves to ST_OPEN once a slot frees and to ST_EMPTY when a squash clears every record.

Top module: `spec_load_buffer`

## Requirements
- R1: After reset no record is live, `alloc_ready` is 1, and `squash_valid` and `retire_valid` are 0.
- R2: Loads are accepted in program order when `alloc_valid` and `alloc_ready` are both 1. Once DEPTH (default 8) records are live with none released, `alloc_ready` is 0 and a load offered then is dropped; a later snoop to its address causes no squash.
- R3: A snoop (`snoop_valid` with `snoop_addr`) equal to the address of a live record makes `squash_valid` 1 for exactly the next cycle with that record's tag on `squash_tag`. The record and all younger records are removed in the same update, so later permissions or snoops to them have no effect.
- R4: When several live records match one snoop, `squash_tag` carries the tag of the oldest of them in program order.
- R5: A snoop whose address matches no live record causes no squash and leaves every record live.
- R6: `perm_valid` with `perm_tag` equal to a live record's tag marks it as ordered. A record that may retire does so at the next clock edge: `retire_valid` is 1 for one cycle with its tag on `retire_tag`. A permission given earlier is remembered.
- R7: With `strict_order` = 1, only the oldest live record may retire. A younger record that has permission waits and retires in the cycle after the older one.
- R8: With `strict_order` = 0, the oldest live record that has permission retires, even if an older record has none.
- R9: If a snoop hits a record in the same cycle as the permission for that record, the squash wins. The record is removed and reported on `squash_tag`, and no retirement is reported for it.
- R10: In a cycle where a snoop hits a live record, `alloc_ready` is 0, and a load offered in that cycle is not recorded.
- R11: A record that has retired is no longer compared, so a snoop to its address causes no squash.
- R12: Records older than a squashed one stay live and can still retire, and the slots freed by a squash are reused by later loads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| strict_order | input | 1 | 1: in-order retirement; 0: oldest permitted record retires |
| alloc_valid | input | 1 | A performed load is offered for tracking |
| alloc_addr | input | ADDR_W | Line address of the offered load |
| alloc_tag | input | TAG_W | Reorder-buffer tag of the offered load |
| alloc_ready | output | 1 | The offered load is accepted this cycle |
| perm_valid | input | 1 | Ordering condition satisfied for one load |
| perm_tag | input | TAG_W | Tag of the load whose ordering condition holds |
| snoop_valid | input | 1 | Coherence invalidation or update seen |
| snoop_addr | input | ADDR_W | Line address of the coherence event |
| squash_valid | output | 1 | One-cycle request to discard a load and all younger work |
| squash_tag | output | TAG_W | Tag of the oldest load to discard |
| retire_valid | output | 1 | One-cycle pulse: a record was released |
| retire_tag | output | TAG_W | Tag of the released record |

## Verification
The main function is driven with three snoop patterns: a snoop to no tracked address, a snoop to exactly one live record, and a snoop that matches several records. The first separates real conflicts from unrelated traffic. The second checks that the victim's tag is reported and that younger records disappear. The third checks that the age order, and not the slot index, picks the reported tag. Permission patterns are given out of program order in both ordering modes, which separates in-order release from oldest-permitted release. Snoops aimed at retired, dropped and squashed addresses show that only live records take part in the comparison.

// File: rtl/slb_pkg.sv
package slb_pkg;
    typedef enum logic [1:0] {
        ST_EMPTY = 2'd0,
        ST_OPEN  = 2'd1,
        ST_FULL  = 2'd2
    } occ_state_e;
endpackage

// File: rtl/slb_oldest_pick.sv
// Finds the first set request bit scanning forward from the head slot,
// i.e. the oldest requester in program order. DEPTH must be a power of two.
module slb_oldest_pick #(
    parameter int DEPTH = 8,
    localparam int PW = $clog2(DEPTH)
) (
    input  logic [DEPTH-1:0] req,
    input  logic [PW-1:0]    head,
    output logic             found,
    output logic [PW-1:0]    idx
);
    logic [PW-1:0] cand;

    always_comb begin
        found = 1'b0;
        idx   = head;
        cand  = head;
        for (int k = 0; k < DEPTH; k++) begin
            cand = head + PW'(k);
            if (!found && req[cand]) begin
                found = 1'b1;
                idx   = cand;
            end
        end
    end
endmodule

// File: rtl/slb_addr_cam.sv
// Parallel compare of one probe address against every live slot.
module slb_addr_cam #(
    parameter int DEPTH  = 8,
    parameter int ADDR_W = 32
) (
    input  logic [DEPTH-1:0]        live,
    input  logic [DEPTH*ADDR_W-1:0] addrs,
    input  logic                    probe_valid,
    input  logic [ADDR_W-1:0]       probe_addr,
    output logic [DEPTH-1:0]        hit
);
    for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
        assign hit[g] = probe_valid && live[g] &&
                        (addrs[g*ADDR_W +: ADDR_W] == probe_addr);
    end
endmodule

// File: rtl/spec_load_buffer.sv
module spec_load_buffer
    import slb_pkg::*;
#(
    parameter int DEPTH  = 8,
    parameter int ADDR_W = 32,
    parameter int TAG_W  = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              strict_order,
    input  logic              alloc_valid,
    input  logic [ADDR_W-1:0] alloc_addr,
    input  logic [TAG_W-1:0]  alloc_tag,
    output logic              alloc_ready,
    input  logic              perm_valid,
    input  logic [TAG_W-1:0]  perm_tag,
    input  logic              snoop_valid,
    input  logic [ADDR_W-1:0] snoop_addr,
    output logic              squash_valid,
    output logic [TAG_W-1:0]  squash_tag,
    output logic              retire_valid,
    output logic [TAG_W-1:0]  retire_tag
);
    localparam int PW = $clog2(DEPTH);

    // Slot storage
    logic [DEPTH-1:0]        valid_q, ord_q, valid_n;
    logic [DEPTH*ADDR_W-1:0] addr_q;
    logic [TAG_W-1:0]        tag_q [DEPTH];
    logic [PW-1:0]           head_q, tail_q, head_n, tail_n;
    occ_state_e              state_q, state_n;

    // Per-slot decode
    logic [DEPTH-1:0] perm_hit, snoop_hit, kill, eligible;
    logic [PW-1:0]    age [DEPTH];
    logic             sq_found, rt_found, hd_found, alloc_go;
    logic [PW-1:0]    sq_idx, rt_idx, hd_idx, sq_age;

    slb_addr_cam #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_cam (
        .live(valid_q), .addrs(addr_q), .probe_valid(snoop_valid),
        .probe_addr(snoop_addr), .hit(snoop_hit)
    );

    // Oldest conflicting record
    slb_oldest_pick #(.DEPTH(DEPTH)) u_pick_squash (
        .req(snoop_hit), .head(head_q), .found(sq_found), .idx(sq_idx)
    );

    assign sq_age = sq_idx - head_q;

    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        assign age[g]      = PW'(g) - head_q;
        assign perm_hit[g] = perm_valid && valid_q[g] && (tag_q[g] == perm_tag);
        assign kill[g]     = sq_found && valid_q[g] && (age[g] >= sq_age);
        assign eligible[g] = valid_q[g] && (ord_q[g] || perm_hit[g]) && !kill[g]
                             && (!strict_order || (PW'(g) == head_q));
    end

    // Oldest record allowed to leave
    slb_oldest_pick #(.DEPTH(DEPTH)) u_pick_retire (
        .req(eligible), .head(head_q), .found(rt_found), .idx(rt_idx)
    );

    assign alloc_ready = (state_q != ST_FULL) && !sq_found;
    assign alloc_go    = alloc_valid && alloc_ready;

    always_comb begin
        valid_n = valid_q & ~kill;
        if (rt_found) valid_n[rt_idx] = 1'b0;
        if (alloc_go) valid_n[tail_q] = 1'b1;
        if (sq_found)      tail_n = sq_idx;
        else if (alloc_go) tail_n = tail_q + PW'(1);
        else               tail_n = tail_q;
    end

    // Next oldest live record after this cycle's updates
    slb_oldest_pick #(.DEPTH(DEPTH)) u_pick_head (
        .req(valid_n), .head(head_q), .found(hd_found), .idx(hd_idx)
    );

    assign head_n = hd_found ? hd_idx : tail_n;

    always_comb begin
        unique case (state_q)
            ST_EMPTY: state_n = alloc_go ? (valid_n[tail_n] ? ST_FULL : ST_OPEN) : ST_EMPTY;
            ST_OPEN:  state_n = !hd_found ? ST_EMPTY : (valid_n[tail_n] ? ST_FULL : ST_OPEN);
            ST_FULL:  state_n = !hd_found ? ST_EMPTY : (valid_n[tail_n] ? ST_FULL : ST_OPEN);
            default:  state_n = ST_EMPTY;
        endcase
    end

    // State and slot register process
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_EMPTY;
            valid_q <= '0;
            ord_q   <= '0;
            head_q  <= '0;
            tail_q  <= '0;
        end else begin
            state_q <= state_n;
            valid_q <= valid_n;
            head_q  <= head_n;
            tail_q  <= tail_n;
            ord_q   <= ord_q | perm_hit;
            if (alloc_go) ord_q[tail_q] <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (alloc_go) begin
            addr_q[tail_q*ADDR_W +: ADDR_W] <= alloc_addr;
            tag_q[tail_q]                   <= alloc_tag;
        end
    end

    // Output process
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            squash_valid <= 1'b0;
            squash_tag   <= '0;
            retire_valid <= 1'b0;
            retire_tag   <= '0;
        end else begin
            squash_valid <= sq_found;
            squash_tag   <= sq_found ? tag_q[sq_idx] : '0;
            retire_valid <= rt_found;
            retire_tag   <= rt_found ? tag_q[rt_idx] : '0;
        end
    end

    AST_EMPTY_NO_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
        state_q == ST_EMPTY |-> valid_q == '0);                            // R1
    AST_FULL_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        state_q == ST_FULL |-> !alloc_ready);                              // R2
    AST_HEAD_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
        state_q != ST_EMPTY |-> valid_q[head_q]);                          // R2
    AST_SQUASH_FOLLOWS_HIT: assert property (@(posedge clk) disable iff (!rst_n)
        (|snoop_hit) |=> squash_valid);                                    // R3
    AST_NO_SQUASH_WITHOUT_SNOOP: assert property (@(posedge clk) disable iff (!rst_n)
        squash_valid |-> $past(snoop_valid));                              // R5
    AST_STRICT_HEAD_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        (strict_order && rt_found) |-> rt_idx == head_q);                  // R7
endmodule

// File: tb/spec_load_buffer_tb.sv
module spec_load_buffer_tb;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 5000;
    localparam int NVEC       = 20;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        strict_order = 1'b1;
    logic        alloc_valid = 1'b0;
    logic [31:0] alloc_addr = '0;
    logic [5:0]  alloc_tag = '0;
    logic        alloc_ready;
    logic        perm_valid = 1'b0;
    logic [5:0]  perm_tag = '0;
    logic        snoop_valid = 1'b0;
    logic [31:0] snoop_addr = '0;
    logic        squash_valid;
    logic [5:0]  squash_tag;
    logic        retire_valid;
    logic [5:0]  retire_tag;

    int n_chk = 0;
    int n_err = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    spec_load_buffer u_dut (
        .clk(clk), .rst_n(rst_n), .strict_order(strict_order),
        .alloc_valid(alloc_valid), .alloc_addr(alloc_addr), .alloc_tag(alloc_tag),
        .alloc_ready(alloc_ready), .perm_valid(perm_valid), .perm_tag(perm_tag),
        .snoop_valid(snoop_valid), .snoop_addr(snoop_addr),
        .squash_valid(squash_valid), .squash_tag(squash_tag),
        .retire_valid(retire_valid), .retire_tag(retire_tag)
    );

    typedef struct packed {
        logic [3:0]  req;
        logic        strict;
        logic        av;
        logic [15:0] aaddr;
        logic [5:0]  atag;
        logic        pv;
        logic [5:0]  ptag;
        logic        sv;
        logic [15:0] saddr;
        logic        esq;
        logic [5:0]  esqtag;
        logic        ert;
        logic [5:0]  erttag;
    } vec_t;

    localparam vec_t VEC [NVEC] = '{
        '{4'd2, 1'b1, 1'b1, 16'h0010, 6'd1, 1'b0, 6'd0, 1'b0, 16'h0000, 1'b0, 6'd0, 1'b0, 6'd0},
        '{4'd2, 1'b1, 1'b1, 16'h0020, 6'd2, 1'b0, 6'd0, 1'b0, 16'h0000, 1'b0, 6'd0, 1'b0, 6'd0},
        '{4'd2, 1'b1, 1'b1, 16'h0030, 6'd3, 1'b0, 6'd0, 1'b0, 16'h0000, 1'b0, 6'd0, 1'b0, 6'd0},
        '{4'd7, 1'b1, 1'b0, 16'h0000, 6'd0, 1'b1, 6'd2, 1'b0, 16'h0000, 1'b0, 6'd0, 1'b0, 6'd0}, // R7 younger waits
        '{4'd6, 1'b1, 1'b0, 16'h0000, 6'd0, 1'b1, 6'd1, 1'b0, 16'h0000, 1'b0, 6'd0, 1'b1, 6'd1}, // R6
        '{4'd7, 1'b1, 1'b0, 16'h0000, 6'd0, 1'b0, 6'd0, 1'b0, 16'h0000, 1'b0, 6'd0, 1'b1, 6'd2}, // R7 then retires
        '{4'd11,1'b1, 1'b0, 16'h0000, 6'd0, 1'b0, 6'd0, 1'b1, 16'h0020, 1'b0, 6'd0, 1'b0, 6'd0}, // R11
        '{4'd5, 1'b1, 1'b0, 16'h0000, 6'd0, 1'b0, 6'd0, 1'b1, 16'h0099, 1'b0, 6'd0, 1'b0, 6'd0}, // R5
        '{4'd2, 1'b1, 1'b1, 16'h0020, 6'd4, 1'b0, 6'd0, 1'b0, 16'h0000, 1'b0, 6'd0, 1'b0, 6'd0},
        '{4'd2, 1'b1, 1'b1, 16'h0030, 6'd5, 1'b0, 6'd0, 1'b0, 16'h0000, 1'b0, 6'd0, 1'b0, 6'd0},
        '{4'd4, 1'b1, 1'b0, 16'h0000, 6'd0, 1'b0, 6'd0, 1'b1, 16'h0030, 1'b1, 6'd3, 1'b0, 6'd0}, // R4 oldest of two
        '{4'd3, 1'b1, 1'b0, 16'h0000, 6'd0, 1'b1, 6'd5, 1'b0, 16'h0000, 1'b0, 6'd0, 1'b0, 6'd0}, // R3 younger gone
        '{4'd2, 1'b1, 1'b1, 16'h0040, 6'd6, 1'b0, 6'd0, 1'b0, 16'h0000, 1'b0, 6'd0, 1'b0, 6'd0},
        '{4'd9, 1'b1, 1'b0, 16'h0000, 6'd0, 1'b1, 6'd6, 1'b1, 16'h0040, 1'b1, 6'd6, 1'b0, 6'd0}, // R9
        '{4'd9, 1'b1, 1'b0, 16'h0000, 6'd0, 1'b0, 6'd0, 1'b0, 16'h0000, 1'b0, 6'd0, 1'b0, 6'd0},
        '{4'd2, 1'b0, 1'b1, 16'h0050, 6'd7, 1'b0, 6'd0, 1'b0, 16'h0000, 1'b0, 6'd0, 1'b0, 6'd0},
        '{4'd2, 1'b0, 1'b1, 16'h0060, 6'd8, 1'b0, 6'd0, 1'b0, 16'h0000, 1'b0, 6'd0, 1'b0, 6'd0},
        '{4'd8, 1'b0, 1'b0, 16'h0000, 6'd0, 1'b1, 6'd8, 1'b0, 16'h0000, 1'b0, 6'd0, 1'b1, 6'd8}, // R8
        '{4'd11,1'b0, 1'b0, 16'h0000, 6'd0, 1'b0, 6'd0, 1'b1, 16'h0060, 1'b0, 6'd0, 1'b0, 6'd0}, // R11
        '{4'd3, 1'b0, 1'b0, 16'h0000, 6'd0, 1'b0, 6'd0, 1'b1, 16'h0050, 1'b1, 6'd7, 1'b0, 6'd0}  // R3
    };

    task automatic check(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Called at a falling edge: drive, take one rising edge, return at the next falling edge.
    task automatic apply(input logic av, input logic [31:0] aa, input logic [5:0] at,
                         input logic pv, input logic [5:0] pt,
                         input logic sv, input logic [31:0] sa);
        alloc_valid = av; alloc_addr = aa; alloc_tag = at;
        perm_valid  = pv; perm_tag   = pt;
        snoop_valid = sv; snoop_addr = sa;
        @(posedge clk);
        @(negedge clk);
        alloc_valid = 1'b0; perm_valid = 1'b0; snoop_valid = 1'b0;
    endtask

    task automatic expect_out(input string req, input logic esq, input int esqtag,
                              input logic ert, input int erttag);
        check(req, "squash_valid", int'(squash_valid), int'(esq));
        if (esq) check(req, "squash_tag", int'(squash_tag), esqtag);
        check(req, "retire_valid", int'(retire_valid), int'(ert));
        if (ert) check(req, "retire_tag", int'(retire_tag), erttag);
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL R1 watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        check("R1", "alloc_ready", int'(alloc_ready), 1);
        check("R1", "squash_valid", int'(squash_valid), 0);
        check("R1", "retire_valid", int'(retire_valid), 0);

        for (int i = 0; i < NVEC; i++) begin
            string rq;
            rq = $sformatf("R%0d", VEC[i].req);
            strict_order = VEC[i].strict;
            apply(VEC[i].av, {16'h0, VEC[i].aaddr}, VEC[i].atag, VEC[i].pv, VEC[i].ptag,
                  VEC[i].sv, {16'h0, VEC[i].saddr});
            expect_out(rq, VEC[i].esq, int'(VEC[i].esqtag), VEC[i].ert, int'(VEC[i].erttag));
        end

        // R2: fill to capacity in strict mode
        strict_order = 1'b1;
        for (int i = 0; i < 8; i++) begin
            check("R2", "alloc_ready before fill", int'(alloc_ready), 1);
            apply(1'b1, 32'h100 + i, 6'(16 + i), 1'b0, 6'd0, 1'b0, 32'h0);
        end
        check("R2", "alloc_ready when full", int'(alloc_ready), 0);
        apply(1'b1, 32'h200, 6'd30, 1'b0, 6'd0, 1'b0, 32'h0);
        apply(1'b0, 32'h0, 6'd0, 1'b0, 6'd0, 1'b1, 32'h200);
        expect_out("R2", 1'b0, 0, 1'b0, 0);

        // R3: hit on youngest record
        apply(1'b0, 32'h0, 6'd0, 1'b0, 6'd0, 1'b1, 32'h107);
        expect_out("R3", 1'b1, 23, 1'b0, 0);
        check("R2", "alloc_ready after squash frees slot", int'(alloc_ready), 1);

        // R10: snoop hit blocks allocation in the same cycle
        alloc_valid = 1'b1; alloc_addr = 32'h300; alloc_tag = 6'd31;
        snoop_valid = 1'b1; snoop_addr = 32'h106;
        #1;
        check("R10", "alloc_ready during hit", int'(alloc_ready), 0);
        @(posedge clk);
        @(negedge clk);
        alloc_valid = 1'b0; snoop_valid = 1'b0;
        expect_out("R10", 1'b1, 22, 1'b0, 0);
        apply(1'b0, 32'h0, 6'd0, 1'b0, 6'd0, 1'b1, 32'h300);
        expect_out("R10", 1'b0, 0, 1'b0, 0);

        // R12: older record still retires after a squash
        apply(1'b0, 32'h0, 6'd0, 1'b1, 6'd16, 1'b0, 32'h0);
        expect_out("R12", 1'b0, 0, 1'b1, 16);
        apply(1'b0, 32'h0, 6'd0, 1'b0, 6'd0, 1'b1, 32'h100);
        expect_out("R11", 1'b0, 0, 1'b0, 0);

        // R12: freed slot reused, then R3 younger removal
        apply(1'b1, 32'h400, 6'd40, 1'b0, 6'd0, 1'b0, 32'h0);
        apply(1'b0, 32'h0, 6'd0, 1'b0, 6'd0, 1'b1, 32'h400);
        expect_out("R12", 1'b1, 40, 1'b0, 0);
        apply(1'b1, 32'h500, 6'd41, 1'b0, 6'd0, 1'b0, 32'h0);
        apply(1'b0, 32'h0, 6'd0, 1'b0, 6'd0, 1'b1, 32'h101);
        expect_out("R3", 1'b1, 17, 1'b0, 0);
        apply(1'b0, 32'h0, 6'd0, 1'b0, 6'd0, 1'b1, 32'h500);
        expect_out("R3", 1'b0, 0, 1'b0, 0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule